// File: doc/BRIEF.md
# Paravirtual Device Legacy Header Registers

This block is the register front end of a paravirtual I/O device that uses the legacy register layout. Software reaches it over a simple register bus. Each access carries a byte address, a size code and, for writes, a 32-bit data word. The header holds:

- the feature words offered by the device and accepted by the driver;
- a selector that picks one of the device's queues, together with that queue's ring page number, size and interrupt vector;
- a doorbell that tells the device a queue has new work;
- the device status byte;
- a pending-interrupt byte that clears when read;
- when message interrupts are on, a vector for configuration-change events.

The header is 20 bytes long with message interrupts off and 24 bytes long with them on. Any access at or past the end of the header is passed to a device-specific configuration window. The window sees an address counted from the end of the header. On the device side the block takes interrupt events from queues and from configuration changes. With message interrupts off it drives a level interrupt. With them on it emits a message strobe that carries the stored vector. It also emits a one-cycle strobe for each doorbell write. A write of zero to the status byte, or a zero ring page number, returns the whole block to its reset state.

Top module: `pvdev_hdr_regs`

## Requirements
- R1: The header decode uses the exact byte offset and ignores the size code. Offset 0 reads `dev_features` ORed with bits 24, 28 and 30 set. Offset 18 reads the status byte and offset 19 reads the pending-interrupt byte. Reads of the doorbell (16) and of any undecoded header offset return 0xFFFFFFFF. The block's registers reset to zero.
- R2: The header length is 20 when `msg_en` is low and 24 when it is high. An access at an address at or above that length asserts `win_valid` with `win_addr` = address − length, and the read data is `win_rdata`.
- R3: A write to offset 4 stores the driver feature word. If bit 30 of the written word is set, the stored value is `dev_fallback_feat` when `dev_has_fallback` is high, and zero when it is low.
- R4: Offset 8 stores a non-zero 32-bit ring page number for the queue named by the selector and reads it back. Offset 12 reads that queue's 16-bit size from the `QSIZE_TABLE` parameter, at entry `i` = bits [16i+15:16i].
- R5: Offset 14 reads and writes the queue selector. A write whose value is not below `NUM_Q` (64) leaves the selector unchanged.
- R6: A write of zero to offset 8, or a write whose low byte is zero to offset 18, resets the block. After the reset the features, selector, status, pending byte and every page number read 0, and every vector reads 0xFFFF.
- R7: A status write stores only bits [7:0]. A pulse on `master_clr` clears status bit 2 (driver ready). If a status write and `master_clr` fall in the same cycle, the clear wins.
- R8: A read of offset 19 returns the pending byte and clears it in the same access. A queue event sets bit 0 and a configuration event sets bit 1. An event in the same cycle as the read survives the clear.
- R9: `irq_level` equals pending bit 0 while `msg_en` is low and stays low while `msg_en` is high.
- R10: With `msg_en` high, a `q_irq` event gives a one-cycle `msg_stb` in the next cycle, with `msg_vec` set to the vector of queue `q_irq_idx`. A `cfg_irq` event does the same with the configuration vector. A queue event takes priority when both arrive in one cycle. No strobe is issued when the chosen vector is 0xFFFF.
- R11: With `msg_en` high, offset 20 holds the configuration vector and offset 22 holds the selected queue's vector. A written value of `NUM_VECTORS` or more is stored as 0xFFFF.
- R12: A write to offset 16 raises `notify_stb` for exactly the next cycle, with `notify_idx` equal to bits [15:0] of the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_en | input | 1 | Message interrupts enabled |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| win_valid | output | 1 | Access forwarded to config window |
| win_write | output | 1 | Forwarded write flag |
| win_size | output | 2 | Forwarded size code |
| win_addr | output | ADDR_W | Rebased window address |
| win_wdata | output | 32 | Forwarded write data |
| win_rdata | input | 32 | Window read data |
| dev_features | input | 32 | Device's own feature bits |
| dev_fallback_feat | input | 32 | Feature set used on a bad negotiation |
| dev_has_fallback | input | 1 | Fallback set is present |
| master_clr | input | 1 | Bus-master enable was cleared |
| q_irq | input | 1 | Queue interrupt event |
| q_irq_idx | input | $clog2(NUM_Q) | Queue raising the event |
| cfg_irq | input | 1 | Configuration-change event |
| irq_level | output | 1 | Legacy level interrupt |
| msg_stb | output | 1 | Message interrupt request |
| msg_vec | output | 16 | Vector of the message |
| notify_stb | output | 1 | Doorbell strobe |
| notify_idx | output | 16 | Queue index from the doorbell |

## Verification
The bench moves the window boundary with `msg_en`. A decoder that used the wrong header length would send offset 22 to the window, or would hide window byte 1 behind a vector register. It reads the pending byte in the same cycle as a new queue event. A design that cleared after setting would lose that interrupt, and the next read would return 0 instead of 1. Two queues are loaded with different page numbers and sizes, and the bench then checks selector writes at 64 and 63. A bank that decoded the selector wrongly, or accepted the out-of-range value, would return the other queue's data. Both soft-reset triggers are followed by reads of every vector, which must return 0xFFFF rather than zero. The bench also tries out-of-range vectors and a vector of 0xFFFF. A block that stored the raw value or still sent a message would fail at readback or at `msg_stb`.

// File: rtl/pvd_pkg.sv
// Shared constants and types for the paravirtual header register block.
// Assumes byte addressing from the base of the register region.
package pvd_pkg;
    localparam int OFS_HOSTF  = 0;
    localparam int OFS_GUESTF = 4;
    localparam int OFS_PFN    = 8;
    localparam int OFS_QSIZE  = 12;
    localparam int OFS_QSEL   = 14;
    localparam int OFS_NOTIFY = 16;
    localparam int OFS_STATUS = 18;
    localparam int OFS_ISR    = 19;
    localparam int OFS_CFGVEC = 20;
    localparam int OFS_QVEC   = 22;

    localparam int HDR_LEN_PLAIN = 20;
    localparam int HDR_LEN_MSG   = 24;

    localparam logic [15:0] NO_VECTOR = 16'hFFFF;

    localparam int FEAT_NOTIFY_EMPTY = 24;
    localparam int FEAT_INDIRECT     = 28;
    localparam int FEAT_BAD          = 30;
    localparam int ST_DRV_READY      = 2;

    typedef enum logic [3:0] {
        HR_NONE, HR_HOSTF, HR_GUESTF, HR_PFN, HR_QSIZE, HR_QSEL,
        HR_NOTIFY, HR_STATUS, HR_ISR, HR_CFGVEC, HR_QVEC, HR_WINDOW
    } hdr_reg_e;
endpackage

// File: rtl/pvd_addr_decode.sv
// Address decoder: maps a byte address to a header register or to the
// device config window. Assumes ADDR_W is wide enough to hold 24.
module pvd_addr_decode
    import pvd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              msg_en,
    input  logic [ADDR_W-1:0] addr,
    output hdr_reg_e          reg_sel,
    output logic [ADDR_W-1:0] win_addr
);
    localparam logic [ADDR_W-1:0] LEN_PLAIN = ADDR_W'(HDR_LEN_PLAIN);
    localparam logic [ADDR_W-1:0] LEN_MSG   = ADDR_W'(HDR_LEN_MSG);

    logic [ADDR_W-1:0] hdr_len;

    // Pick header length, then classify the address against it.
    always_comb begin
        hdr_len  = msg_en ? LEN_MSG : LEN_PLAIN;
        win_addr = '0;
        reg_sel  = HR_NONE;
        if (addr >= hdr_len) begin
            reg_sel  = HR_WINDOW;
            win_addr = addr - hdr_len;
        end else begin
            case (addr)
                ADDR_W'(OFS_HOSTF):  reg_sel = HR_HOSTF;
                ADDR_W'(OFS_GUESTF): reg_sel = HR_GUESTF;
                ADDR_W'(OFS_PFN):    reg_sel = HR_PFN;
                ADDR_W'(OFS_QSIZE):  reg_sel = HR_QSIZE;
                ADDR_W'(OFS_QSEL):   reg_sel = HR_QSEL;
                ADDR_W'(OFS_NOTIFY): reg_sel = HR_NOTIFY;
                ADDR_W'(OFS_STATUS): reg_sel = HR_STATUS;
                ADDR_W'(OFS_ISR):    reg_sel = HR_ISR;
                ADDR_W'(OFS_CFGVEC): reg_sel = HR_CFGVEC;
                ADDR_W'(OFS_QVEC):   reg_sel = HR_QVEC;
                default:             reg_sel = HR_NONE;
            endcase
        end
    end

    // R2: vector offsets only decode while the longer header is active.
    always_comb begin
        if ((reg_sel == HR_CFGVEC) || (reg_sel == HR_QVEC))
            assert_vec_needs_msg_R2: assert (msg_en);
    end
endmodule

// File: rtl/pvd_queue_bank.sv
// Per-queue storage: ring page number and interrupt vector for each queue.
// Writes go to the selected queue; a second port looks up any queue's vector
// for interrupt delivery. Assumes sel is always below NUM_Q.
module pvd_queue_bank
    import pvd_pkg::*;
#(
    parameter int NUM_Q       = 64,
    parameter int NUM_VECTORS = 4,
    localparam int QW         = $clog2(NUM_Q)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [QW-1:0] sel,
    input  logic          pfn_we,
    input  logic [31:0]   pfn_wdata,
    input  logic          vec_we,
    input  logic [15:0]   vec_wdata,
    input  logic [QW-1:0] lookup_idx,
    output logic [31:0]   pfn_rd,
    output logic [15:0]   vec_rd,
    output logic [15:0]   vec_lookup
);
    logic [31:0] pfn_all [NUM_Q];
    logic [15:0] vec_all [NUM_Q];
    logic        vec_ok;

    // Allocation check: only vectors below NUM_VECTORS are accepted.
    assign vec_ok = 32'(vec_wdata) < 32'(NUM_VECTORS);

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_q
        logic [31:0] pfn_r;
        logic [15:0] vec_r;
        // One queue's page number and vector, written when selected.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                pfn_r <= '0;
                vec_r <= NO_VECTOR;
            end else if (sel == QW'(gi)) begin
                if (pfn_we) pfn_r <= pfn_wdata;
                if (vec_we) vec_r <= vec_ok ? vec_wdata : NO_VECTOR;
            end
        end
        assign pfn_all[gi] = pfn_r;
        assign vec_all[gi] = vec_r;
    end

    assign pfn_rd     = pfn_all[sel];
    assign vec_rd     = vec_all[sel];
    assign vec_lookup = vec_all[lookup_idx];

    // R4: a stored page number reads back on the next cycle.
    assert_pfn_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pfn_we && !clr) |=> (pfn_rd == $past(pfn_wdata)));

    // R11: an unallocatable vector reads back as the no-vector code.
    assert_bad_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_we && !clr && (32'(vec_wdata) >= 32'(NUM_VECTORS))) |=> (vec_rd == NO_VECTOR));
endmodule

// File: rtl/pvd_irq_unit.sv
// Interrupt unit: pending byte with read-to-clear, legacy level output and
// message strobe. Assumes q_vec is the vector of the queue raising q_irq.
module pvd_irq_unit
    import pvd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        msg_en,
    input  logic        isr_rd,
    input  logic        q_irq,
    input  logic        cfg_irq,
    input  logic [15:0] q_vec,
    input  logic [15:0] cfg_vec,
    output logic [7:0]  isr_q,
    output logic        irq_level,
    output logic        msg_stb,
    output logic [15:0] msg_vec
);
    logic [7:0]  isr_set;
    logic [15:0] pick_vec;

    assign isr_set  = {6'b0, cfg_irq, q_irq};
    assign pick_vec = q_irq ? q_vec : cfg_vec;

    // Pending byte: a read clears it, new events of the same cycle survive.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) isr_q <= '0;
        else               isr_q <= (isr_rd ? 8'h00 : isr_q) | isr_set;
    end

    // Message request: queue event first, skipped on the no-vector code.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            msg_stb <= 1'b0;
            msg_vec <= NO_VECTOR;
        end else begin
            msg_stb <= msg_en && (q_irq || cfg_irq) && (pick_vec != NO_VECTOR);
            msg_vec <= pick_vec;
        end
    end

    assign irq_level = !msg_en && isr_q[0];

    // R8: a read with no new event leaves the byte empty.
    assert_isr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !q_irq && !cfg_irq) |=> (isr_q == 8'h00));

    // R8: pending bits never drop without a read or a reset.
    assert_isr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!isr_rd && !clr) |=> ((isr_q & $past(isr_q)) == $past(isr_q)));

    // R10: a message never carries the no-vector code.
    assert_msg_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_stb |-> (msg_vec != NO_VECTOR));
endmodule

// File: rtl/pvdev_hdr_regs.sv
// Top of the paravirtual legacy header: feature, selector, status and
// config-vector registers, read mux, doorbell strobe and window forwarding.
// Assumes one access per cycle; read data is combinational in that cycle.
module pvdev_hdr_regs
    import pvd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_Q       = 64,
    parameter int NUM_VECTORS = 4,
    parameter logic [NUM_Q*16-1:0] QSIZE_TABLE = {NUM_Q{16'd256}},
    localparam int QW         = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_en,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              win_valid,
    output logic              win_write,
    output logic [1:0]        win_size,
    output logic [ADDR_W-1:0] win_addr,
    output logic [31:0]       win_wdata,
    input  logic [31:0]       win_rdata,
    input  logic [31:0]       dev_features,
    input  logic [31:0]       dev_fallback_feat,
    input  logic              dev_has_fallback,
    input  logic              master_clr,
    input  logic              q_irq,
    input  logic [QW-1:0]     q_irq_idx,
    input  logic              cfg_irq,
    output logic              irq_level,
    output logic              msg_stb,
    output logic [15:0]       msg_vec,
    output logic              notify_stb,
    output logic [15:0]       notify_idx
);
    localparam logic [31:0] FORCED_FEAT =
        (32'd1 << FEAT_NOTIFY_EMPTY) | (32'd1 << FEAT_INDIRECT) | (32'd1 << FEAT_BAD);

    hdr_reg_e    reg_sel;
    logic        wr, rd, soft_rst;
    logic [31:0] guest_feat;
    logic [15:0] qsel;
    logic [7:0]  status;
    logic [15:0] cfg_vec;
    logic [31:0] pfn_rd;
    logic [15:0] qvec_rd, qvec_lookup;
    logic [7:0]  isr_q;
    logic [7:0]  status_nxt;

    assign wr = bus_valid && bus_write;
    assign rd = bus_valid && !bus_write;

    pvd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .msg_en   (msg_en),
        .addr     (bus_addr),
        .reg_sel  (reg_sel),
        .win_addr (win_addr)
    );

    // Soft reset: zero page number or a zero status byte.
    assign soft_rst = wr && (((reg_sel == HR_PFN) && (bus_wdata == 32'd0)) ||
                             ((reg_sel == HR_STATUS) && (bus_wdata[7:0] == 8'd0)));

    pvd_queue_bank #(.NUM_Q(NUM_Q), .NUM_VECTORS(NUM_VECTORS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .sel        (qsel[QW-1:0]),
        .pfn_we     (wr && (reg_sel == HR_PFN) && (bus_wdata != 32'd0)),
        .pfn_wdata  (bus_wdata),
        .vec_we     (wr && (reg_sel == HR_QVEC)),
        .vec_wdata  (bus_wdata[15:0]),
        .lookup_idx (q_irq_idx),
        .pfn_rd     (pfn_rd),
        .vec_rd     (qvec_rd),
        .vec_lookup (qvec_lookup)
    );

    pvd_irq_unit u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .msg_en    (msg_en),
        .isr_rd    (rd && (reg_sel == HR_ISR)),
        .q_irq     (q_irq),
        .cfg_irq   (cfg_irq),
        .q_vec     (qvec_lookup),
        .cfg_vec   (cfg_vec),
        .isr_q     (isr_q),
        .irq_level (irq_level),
        .msg_stb   (msg_stb),
        .msg_vec   (msg_vec)
    );

    // Next status: write takes low byte, bus-master clear drops driver-ready.
    always_comb begin
        status_nxt = (wr && (reg_sel == HR_STATUS)) ? bus_wdata[7:0] : status;
        if (master_clr) status_nxt[ST_DRV_READY] = 1'b0;
    end

    // Driver-visible scalar registers with hardware and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            guest_feat <= '0;
            qsel       <= '0;
            status     <= '0;
            cfg_vec    <= NO_VECTOR;
        end else begin
            status <= status_nxt;
            if (wr && (reg_sel == HR_GUESTF))
                guest_feat <= bus_wdata[FEAT_BAD]
                              ? (dev_has_fallback ? dev_fallback_feat : 32'd0)
                              : bus_wdata;
            if (wr && (reg_sel == HR_QSEL) && (32'(bus_wdata[15:0]) < 32'(NUM_Q)))
                qsel <= bus_wdata[15:0];
            if (wr && (reg_sel == HR_CFGVEC))
                cfg_vec <= (32'(bus_wdata[15:0]) < 32'(NUM_VECTORS))
                           ? bus_wdata[15:0] : NO_VECTOR;
        end
    end

    // Doorbell strobe: one cycle after the write, carrying the queue index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_stb <= 1'b0;
            notify_idx <= '0;
        end else begin
            notify_stb <= wr && (reg_sel == HR_NOTIFY);
            notify_idx <= bus_wdata[15:0];
        end
    end

    // Read mux: undecoded offsets and the doorbell return all ones.
    always_comb begin
        unique case (reg_sel)
            HR_HOSTF:  bus_rdata = dev_features | FORCED_FEAT;
            HR_GUESTF: bus_rdata = guest_feat;
            HR_PFN:    bus_rdata = pfn_rd;
            HR_QSIZE:  bus_rdata = {16'd0, QSIZE_TABLE[int'(qsel[QW-1:0])*16 +: 16]};
            HR_QSEL:   bus_rdata = {16'd0, qsel};
            HR_STATUS: bus_rdata = {24'd0, status};
            HR_ISR:    bus_rdata = {24'd0, isr_q};
            HR_CFGVEC: bus_rdata = {16'd0, cfg_vec};
            HR_QVEC:   bus_rdata = {16'd0, qvec_rd};
            HR_WINDOW: bus_rdata = win_rdata;
            default:   bus_rdata = 32'hFFFF_FFFF;
        endcase
    end

    // Window forwarding of everything past the header.
    assign win_valid = bus_valid && (reg_sel == HR_WINDOW);
    assign win_write = bus_write;
    assign win_size  = bus_size;
    assign win_wdata = bus_wdata;

    // R5: an out-of-range selector write changes nothing.
    assert_sel_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (reg_sel == HR_QSEL) && (32'(bus_wdata[15:0]) >= 32'(NUM_Q))) |=> $stable(qsel));

    // R6: a soft reset leaves the scalar registers cleared.
    assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((status == 8'd0) && (qsel == 16'd0) && (guest_feat == 32'd0)
                      && (cfg_vec == NO_VECTOR)));

    // R7: after a bus-master clear the driver-ready bit is low.
    assert_master_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        master_clr |=> !status[ST_DRV_READY]);

    // R12: a doorbell write gives the strobe with the written index.
    assert_notify_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (reg_sel == HR_NOTIFY)) |=> (notify_stb && (notify_idx == $past(bus_wdata[15:0]))));
endmodule

// File: tb/pvdev_hdr_regs_tb.sv
`timescale 1ns/1ps
module pvdev_hdr_regs_tb;
    localparam int ADDR_W = 8;
    localparam int NQ     = 64;
    localparam int QW     = 6;

    function automatic logic [NQ*16-1:0] mk_sizes();
        logic [NQ*16-1:0] t;
        t = '0;
        for (int i = 0; i < NQ; i++) t[i*16 +: 16] = 16'(16 + 4*i);
        return t;
    endfunction
    localparam logic [NQ*16-1:0] TB_QSIZES = mk_sizes();

    logic clk = 1'b0, rst_n = 1'b0, msg_en = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0] bus_size = 2'd2;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic win_valid, win_write;
    logic [1:0] win_size;
    logic [ADDR_W-1:0] win_addr;
    logic [31:0] win_wdata;
    logic [31:0] win_rdata = 32'h1234_5678;
    logic [31:0] dev_features = 32'h0000_00A5, dev_fallback_feat = 32'h0000_0033;
    logic dev_has_fallback = 1'b1, master_clr = 1'b0;
    logic q_irq = 1'b0, cfg_irq = 1'b0;
    logic [QW-1:0] q_irq_idx = '0;
    logic irq_level, msg_stb, notify_stb;
    logic [15:0] msg_vec, notify_idx;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pvdev_hdr_regs #(.ADDR_W(ADDR_W), .NUM_Q(NQ), .NUM_VECTORS(4), .QSIZE_TABLE(TB_QSIZES)) u_dut (
        .clk(clk), .rst_n(rst_n), .msg_en(msg_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .win_valid(win_valid), .win_write(win_write), .win_size(win_size),
        .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .dev_features(dev_features), .dev_fallback_feat(dev_fallback_feat),
        .dev_has_fallback(dev_has_fallback), .master_clr(master_clr),
        .q_irq(q_irq), .q_irq_idx(q_irq_idx), .cfg_irq(cfg_irq),
        .irq_level(irq_level), .msg_stb(msg_stb), .msg_vec(msg_vec),
        .notify_stb(notify_stb), .notify_idx(notify_idx)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(addr);
        #2 data = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int addr, input logic [31:0] exp);
        logic [31:0] d;
        rd(addr, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 status reset", 18, 32'h0);
        rd_chk("R1 isr reset", 19, 32'h0);
        rd_chk("R5 sel reset", 14, 32'h0);
        rd_chk("R3 guest reset", 4, 32'h0);
        chk("R9 irq reset", {31'd0, irq_level}, 32'h0);
        chk("R12 notify reset", {31'd0, notify_stb}, 32'h0);
        rd_chk("R1 host features forced bits", 0, 32'h5100_00A5);
        rd_chk("R1 unmapped offset", 2, 32'hFFFF_FFFF);
        rd_chk("R1 doorbell read", 16, 32'hFFFF_FFFF);
    endtask

    task automatic t_window();
        logic [31:0] d;
        msg_en = 1'b0;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'd20;
        #2;
        chk("R2 window valid short hdr", {31'd0, win_valid}, 32'h1);
        chk("R2 window addr short hdr", 32'(win_addr), 32'h0);
        chk("R2 window data", bus_rdata, 32'h1234_5678);
        @(negedge clk); bus_valid = 1'b0;
        msg_en = 1'b1;
        rd_chk("R2 offset 22 is header with msg", 22, 32'h0000_FFFF);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 8'd25;
        #2;
        chk("R2 window valid long hdr", {31'd0, win_valid}, 32'h1);
        chk("R2 window addr long hdr", 32'(win_addr), 32'h1);
        @(negedge clk); bus_valid = 1'b0;
        rd(22, d);
        chk("R2 no window at 22", {31'd0, win_valid}, 32'h0);
        msg_en = 1'b0;
    endtask

    task automatic t_features();
        wr(4, 32'h0000_0F0F);
        rd_chk("R3 plain guest write", 4, 32'h0000_0F0F);
        dev_has_fallback = 1'b1;
        wr(4, 32'h4000_0001);
        rd_chk("R3 bad bit uses fallback", 4, 32'h0000_0033);
        dev_has_fallback = 1'b0;
        wr(4, 32'h4000_0001);
        rd_chk("R3 bad bit no fallback", 4, 32'h0);
        wr(0, 32'hDEAD_BEEF);
        rd_chk("R1 host features read-only", 0, 32'h5100_00A5);
    endtask

    task automatic t_queue();
        wr(14, 32'd3); wr(8, 32'h0000_1234);
        wr(14, 32'd5); wr(8, 32'h0000_0099);
        wr(14, 32'd3);
        rd_chk("R4 pfn queue 3", 8, 32'h0000_1234);
        rd_chk("R4 size queue 3", 12, 32'd28);
        wr(14, 32'd5);
        rd_chk("R4 pfn queue 5", 8, 32'h0000_0099);
        rd_chk("R4 size queue 5", 12, 32'd36);
    endtask

    task automatic t_sel();
        wr(14, 32'd64);
        rd_chk("R5 selector 64 ignored", 14, 32'd5);
        rd_chk("R5 pfn still queue 5", 8, 32'h0000_0099);
        wr(14, 32'd63);
        rd_chk("R5 selector 63 taken", 14, 32'd63);
    endtask

    task automatic t_vectors();
        msg_en = 1'b1;
        wr(20, 32'd2);
        rd_chk("R11 cfg vector valid", 20, 32'd2);
        wr(20, 32'd4);
        rd_chk("R11 cfg vector too big", 20, 32'h0000_FFFF);
        wr(14, 32'd3);
        wr(22, 32'd9);
        rd_chk("R11 queue vector too big", 22, 32'h0000_FFFF);
        wr(22, 32'd1);
        rd_chk("R11 queue vector valid", 22, 32'd1);
        wr(20, 32'd2);
    endtask

    task automatic pulse(input logic qi, input logic ci);
        @(negedge clk);
        q_irq = qi; cfg_irq = ci; q_irq_idx = 6'd3;
        @(negedge clk);
        q_irq = 1'b0; cfg_irq = 1'b0;
        #1;
    endtask

    task automatic t_msg();
        msg_en = 1'b1;
        pulse(1'b1, 1'b0);
        chk("R10 queue message strobe", {31'd0, msg_stb}, 32'h1);
        chk("R10 queue message vector", 32'(msg_vec), 32'd1);
        chk("R9 no legacy irq with msg", {31'd0, irq_level}, 32'h0);
        @(negedge clk);
        chk("R10 strobe one cycle", {31'd0, msg_stb}, 32'h0);
        pulse(1'b0, 1'b1);
        chk("R10 config message vector", 32'(msg_vec), 32'd2);
        chk("R10 config message strobe", {31'd0, msg_stb}, 32'h1);
        pulse(1'b1, 1'b1);
        chk("R10 queue wins", 32'(msg_vec), 32'd1);
        wr(20, 32'hFFFF);
        pulse(1'b0, 1'b1);
        chk("R10 no message on no-vector", {31'd0, msg_stb}, 32'h0);
    endtask

    task automatic t_isr();
        logic [31:0] d;
        msg_en = 1'b0;
        rd(19, d);
        rd_chk("R8 cleared by read", 19, 32'h0);
        pulse(1'b1, 1'b0);
        chk("R9 legacy irq follows bit0", {31'd0, irq_level}, 32'h1);
        rd_chk("R8 read returns queue bit", 19, 32'h1);
        chk("R8 irq low after read", {31'd0, irq_level}, 32'h0);
        pulse(1'b0, 1'b1);
        chk("R9 config bit does not raise irq", {31'd0, irq_level}, 32'h0);
        rd_chk("R8 config bit", 19, 32'h2);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'd19; q_irq = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0; q_irq = 1'b0;
        chk("R8 read value with same-cycle event", d, 32'h0);
        rd_chk("R8 same-cycle event survives", 19, 32'h1);
    endtask

    task automatic t_status();
        wr(18, 32'h0000_0107);
        rd_chk("R7 status low byte", 18, 32'h07);
        @(negedge clk); master_clr = 1'b1;
        @(negedge clk); master_clr = 1'b0;
        rd_chk("R7 master clear drops ready", 18, 32'h03);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'd18; bus_wdata = 32'h0F; master_clr = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; master_clr = 1'b0;
        rd_chk("R7 clear beats write", 18, 32'h0B);
    endtask

    task automatic t_notify();
        wr(16, 32'h0001_002A);
        #1;
        chk("R12 strobe high", {31'd0, notify_stb}, 32'h1);
        chk("R12 index", 32'(notify_idx), 32'h2A);
        @(negedge clk); #1;
        chk("R12 strobe one cycle", {31'd0, notify_stb}, 32'h0);
    endtask

    task automatic t_softreset(input bit use_status);
        msg_en = 1'b1;
        wr(14, 32'd3); wr(8, 32'h0000_0777); wr(22, 32'd1); wr(20, 32'd2);
        wr(4, 32'h0000_0005); wr(18, 32'h07);
        pulse(1'b0, 1'b1);
        if (use_status) wr(18, 32'h0000_0100);
        else            wr(8, 32'h0);
        rd_chk(use_status ? "R6 status reset: status" : "R6 pfn reset: status", 18, 32'h0);
        rd_chk("R6 selector zero", 14, 32'h0);
        rd_chk("R6 guest zero", 4, 32'h0);
        rd_chk("R6 isr zero", 19, 32'h0);
        rd_chk("R6 cfg vector none", 20, 32'h0000_FFFF);
        wr(14, 32'd3);
        rd_chk("R6 pfn zero", 8, 32'h0);
        rd_chk("R6 queue vector none", 22, 32'h0000_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_features();
        t_queue();
        t_sel();
        t_vectors();
        t_msg();
        t_isr();
        t_status();
        t_notify();
        t_softreset(1'b0);
        t_softreset(1'b1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule